// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block keeps the stack pointer of an 8-bit microcontroller core. The pointer is 11 bits wide. It is held as a low byte plus a 3-bit extension. For every push or pop request the block gives the memory address to write or read. It also gives a flag that says which memory that address belongs to: the 256-byte internal RAM (addresses up to 0FFh) or the on-chip extended RAM (0100h to 07FFh).

A configuration bit picks the mode. With the bit clear the pointer behaves like the classic 8-bit pointer: it wraps inside internal RAM and the extension register is hidden. With the bit set the pointer carries into the extension, so the stack can grow into extended RAM.

Software reaches both pointer bytes and the configuration bit through a special-function-register (SFR) write port and an SFR read port. Reads are combinational. The address and select outputs are valid in the same cycle as the request. The core uses them directly to reach the RAM arrays, which sit outside this block.

Top module: `stkptr_ext`

## Requirements
- R1: After reset the low pointer byte reads 07h and both the extension and the configuration read 00h. With no request active, the address output is 007h and the select flag is 0.
- R2: A push (push_req high, pop_req low) drives the address pointer+1 in its own cycle. After that clock edge the pointer equals this address.
- R3: A pop (pop_req high, push_req low) drives the current pointer as the address in its own cycle. After that clock edge the pointer is one lower.
- R4: In normal mode (mode bit 0) the low byte wraps: a push at FFh gives 00h and a pop at 00h gives FFh. The extension does not change, the address always has upper bits 0, and the select flag is always 0.
- R5: In extended mode (mode bit 1) the pointer moves as one 11-bit value: a push at 0FFh gives 100h and a pop at 100h gives 0FFh.
- R6: The select flag is 1 (extended RAM) exactly when the address output is above 0FFh.
- R7: The low pointer byte is at SFR address 81h and the extension at B7h. The mode enable is bit 7 of the configuration register at AFh, whose other bits read 0. Any other read address returns 00h.
- R8: In normal mode B7h reads 00h and a write to it is ignored. A value written in extended mode is kept while the mode is off, and it shows again when the mode is turned back on.
- R9: Bits 7..3 of the extension read 0, and writes to them are ignored.
- R10: An SFR write that changes a pointer byte takes priority over a push or pop in the same cycle. The operation is dropped, and the address output shows the unchanged pointer in that cycle.
- R11: A push and a pop in the same cycle leave the pointer unchanged, and the address output shows the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_req | input | 1 | Push or call request |
| pop_req | input | 1 | Pop or return request |
| sfr_wr_en | input | 1 | SFR write strobe |
| sfr_wr_addr | input | 8 | SFR write address |
| sfr_wr_data | input | 8 | SFR write data |
| sfr_rd_addr | input | 8 | SFR read address |
| sfr_rd_data | output | 8 | SFR read data (combinational) |
| stk_addr | output | 11 | Stack access address for the current request |
| stk_xram | output | 1 | 1 = extended RAM, 0 = internal RAM |

## Verification
The address and select outputs are due in the same cycle as the request, because they depend only on the registered pointer and the request inputs. The new pointer value is due after the next rising edge, and so is any SFR write. The bench changes inputs on the falling edge and checks the address and select outputs 1 ns later, well before the edge that consumes the request. It then checks pointer effects through the SFR read port 1 ns after that rising edge. Reset release passes a two-stage synchronizer, so the bench waits several cycles before its first check.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int unsigned PTR_W_DEF = 11;
  localparam int unsigned LO_W_DEF  = 8;

  typedef enum logic {
    MEM_IRAM = 1'b0,
    MEM_XRAM = 1'b1
  } mem_sel_e;
endpackage

// File: rtl/stk_next_calc.sv
module stk_next_calc #(
  parameter int unsigned PTR_W = 11,
  parameter int unsigned LO_W  = 8,
  localparam int unsigned HI_W = PTR_W - LO_W
) (
  input  logic [LO_W-1:0]  lo_q,
  input  logic [HI_W-1:0]  hi_q,
  input  logic             ext_en,
  input  logic             do_push,
  input  logic             do_pop,
  output logic [LO_W-1:0]  lo_nxt,
  output logic [HI_W-1:0]  hi_nxt,
  output logic [PTR_W-1:0] acc_addr
);
  logic [PTR_W-1:0] cur_eff;
  logic [PTR_W-1:0] full_inc;
  logic [PTR_W-1:0] full_dec;
  logic [LO_W-1:0]  lo_inc;
  logic [LO_W-1:0]  lo_dec;

  always_comb begin
    cur_eff  = {(ext_en ? hi_q : {HI_W{1'b0}}), lo_q};
    full_inc = cur_eff + 1'b1;
    full_dec = cur_eff - 1'b1;
    lo_inc   = lo_q + 1'b1;
    lo_dec   = lo_q - 1'b1;
  end

  always_comb begin
    lo_nxt = lo_q;
    hi_nxt = hi_q;
    if (do_push) begin
      if (ext_en) {hi_nxt, lo_nxt} = full_inc;
      else        lo_nxt = lo_inc;
    end else if (do_pop) begin
      if (ext_en) {hi_nxt, lo_nxt} = full_dec;
      else        lo_nxt = lo_dec;
    end
  end

  always_comb begin
    if (do_push) acc_addr = ext_en ? full_inc : {{HI_W{1'b0}}, lo_inc};
    else         acc_addr = cur_eff;
  end
endmodule

// File: rtl/stk_sfr_read.sv
module stk_sfr_read #(
  parameter int unsigned LO_W     = 8,
  parameter int unsigned HI_W     = 3,
  parameter logic [7:0]  LO_ADDR  = 8'h81,
  parameter logic [7:0]  HI_ADDR  = 8'hB7,
  parameter logic [7:0]  CFG_ADDR = 8'hAF,
  parameter int unsigned MODE_BIT = 7
) (
  input  logic [7:0]      rd_addr,
  input  logic [LO_W-1:0] lo_q,
  input  logic [HI_W-1:0] hi_q,
  input  logic            ext_en,
  output logic [7:0]      rd_data
);
  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == LO_ADDR) begin
      rd_data = lo_q;
    end else if (rd_addr == HI_ADDR) begin
      if (ext_en) rd_data = {{(8-HI_W){1'b0}}, hi_q};
    end else if (rd_addr == CFG_ADDR) begin
      rd_data[MODE_BIT] = ext_en;
    end
  end
endmodule

// File: rtl/stkptr_ext.sv
module stkptr_ext
  import stk_pkg::*;
#(
  parameter int unsigned PTR_W    = PTR_W_DEF,
  parameter int unsigned LO_W     = LO_W_DEF,
  parameter logic [7:0]  LO_ADDR  = 8'h81,
  parameter logic [7:0]  HI_ADDR  = 8'hB7,
  parameter logic [7:0]  CFG_ADDR = 8'hAF,
  parameter int unsigned MODE_BIT = 7,
  parameter logic [7:0]  LO_RST   = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             sfr_wr_en,
  input  logic [7:0]       sfr_wr_addr,
  input  logic [7:0]       sfr_wr_data,
  input  logic [7:0]       sfr_rd_addr,
  output logic [7:0]       sfr_rd_data,
  output logic [PTR_W-1:0] stk_addr,
  output logic             stk_xram
);
  localparam int unsigned HI_W = PTR_W - LO_W;

  logic rst_meta_n, rst_sync_n;
  logic [LO_W-1:0] sp_lo_q, sp_lo_d, lo_calc;
  logic [HI_W-1:0] sp_hi_q, sp_hi_d, hi_calc;
  logic ext_en_q, ext_en_d;
  logic wr_lo, wr_hi, wr_cfg, ptr_wr_hit;
  logic do_push, do_pop;
  logic [PTR_W-1:0] acc_addr;
  mem_sel_e mem_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    wr_lo      = sfr_wr_en && (sfr_wr_addr == LO_ADDR);
    wr_hi      = sfr_wr_en && (sfr_wr_addr == HI_ADDR) && ext_en_q;
    wr_cfg     = sfr_wr_en && (sfr_wr_addr == CFG_ADDR);
    ptr_wr_hit = wr_lo || wr_hi;
    do_push    = push_req && !pop_req && !ptr_wr_hit;
    do_pop     = pop_req && !push_req && !ptr_wr_hit;
  end

  stk_next_calc #(.PTR_W(PTR_W), .LO_W(LO_W)) u_calc (
    .lo_q     (sp_lo_q),
    .hi_q     (sp_hi_q),
    .ext_en   (ext_en_q),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .lo_nxt   (lo_calc),
    .hi_nxt   (hi_calc),
    .acc_addr (acc_addr)
  );

  always_comb begin
    sp_lo_d  = lo_calc;
    sp_hi_d  = hi_calc;
    ext_en_d = ext_en_q;
    if (wr_lo)  sp_lo_d  = sfr_wr_data[LO_W-1:0];
    if (wr_hi)  sp_hi_d  = sfr_wr_data[HI_W-1:0];
    if (wr_cfg) ext_en_d = sfr_wr_data[MODE_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sp_lo_q  <= LO_RST[LO_W-1:0];
      sp_hi_q  <= '0;
      ext_en_q <= 1'b0;
    end else begin
      sp_lo_q  <= sp_lo_d;
      sp_hi_q  <= sp_hi_d;
      ext_en_q <= ext_en_d;
    end
  end

  stk_sfr_read #(
    .LO_W(LO_W), .HI_W(HI_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR),
    .CFG_ADDR(CFG_ADDR), .MODE_BIT(MODE_BIT)
  ) u_rd (
    .rd_addr (sfr_rd_addr),
    .lo_q    (sp_lo_q),
    .hi_q    (sp_hi_q),
    .ext_en  (ext_en_q),
    .rd_data (sfr_rd_data)
  );

  always_comb begin
    mem_sel  = (|acc_addr[PTR_W-1:LO_W]) ? MEM_XRAM : MEM_IRAM;
    stk_addr = acc_addr;
    stk_xram = (mem_sel == MEM_XRAM);
  end
endmodule

// File: rtl/stkptr_ext_chk.sv
module stkptr_ext_chk #(
  parameter int unsigned PTR_W   = 11,
  parameter int unsigned LO_W    = 8,
  parameter int unsigned HI_W    = 3,
  parameter logic [7:0]  LO_ADDR = 8'h81,
  parameter logic [7:0]  HI_ADDR = 8'hB7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_req,
  input logic             pop_req,
  input logic             ptr_wr_hit,
  input logic             sfr_wr_en,
  input logic [7:0]       sfr_wr_addr,
  input logic [7:0]       sfr_wr_data,
  input logic [7:0]       sfr_rd_addr,
  input logic [7:0]       sfr_rd_data,
  input logic [LO_W-1:0]  sp_lo_q,
  input logic             ext_en_q,
  input logic [PTR_W-1:0] stk_addr,
  input logic             stk_xram
);
  a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !ptr_wr_hit) |=> (sp_lo_q == $past(stk_addr[LO_W-1:0])));

  a_r3_pop_reads_top: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !ptr_wr_hit) |-> (stk_addr[LO_W-1:0] == sp_lo_q));

  a_r4_normal_iram: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en_q |-> !stk_xram);

  a_r6_sel_high_addr: assert property (@(posedge clk) disable iff (!rst_n)
    stk_xram |-> (stk_addr[PTR_W-1:LO_W] != '0));

  a_r8_hidden_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd_addr == HI_ADDR && !ext_en_q) |-> (sfr_rd_data == 8'h00));

  a_r9_ext_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd_addr == HI_ADDR) |-> (sfr_rd_data[7:HI_W] == '0));

  a_r10_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr_en && sfr_wr_addr == LO_ADDR) |=> (sp_lo_q == $past(sfr_wr_data[LO_W-1:0])));

  a_r11_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !sfr_wr_en) |=> $stable(sp_lo_q));
endmodule

bind stkptr_ext stkptr_ext_chk #(
  .PTR_W(PTR_W), .LO_W(LO_W), .HI_W(HI_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .push_req    (push_req),
  .pop_req     (pop_req),
  .ptr_wr_hit  (ptr_wr_hit),
  .sfr_wr_en   (sfr_wr_en),
  .sfr_wr_addr (sfr_wr_addr),
  .sfr_wr_data (sfr_wr_data),
  .sfr_rd_addr (sfr_rd_addr),
  .sfr_rd_data (sfr_rd_data),
  .sp_lo_q     (sp_lo_q),
  .ext_en_q    (ext_en_q),
  .stk_addr    (stk_addr),
  .stk_xram    (stk_xram)
);

// File: tb/stkptr_ext_test.sv
`timescale 1ns/1ps
module stkptr_ext_test;
  logic        clk;
  logic        rst_n;
  logic        push_req, pop_req;
  logic        sfr_wr_en;
  logic [7:0]  sfr_wr_addr, sfr_wr_data, sfr_rd_addr;
  logic [7:0]  sfr_rd_data;
  logic [10:0] stk_addr;
  logic        stk_xram;
  int n_chk = 0;
  int n_fail = 0;

  stkptr_ext uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .sfr_wr_en(sfr_wr_en), .sfr_wr_addr(sfr_wr_addr), .sfr_wr_data(sfr_wr_data),
    .sfr_rd_addr(sfr_rd_addr), .sfr_rd_data(sfr_rd_data),
    .stk_addr(stk_addr), .stk_xram(stk_xram)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr_en = 1'b1; sfr_wr_addr = a; sfr_wr_data = d;
    @(posedge clk); #1;
    sfr_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    sfr_rd_addr = a;
    #1;
    chk(tag, {8'h00, sfr_rd_data}, {8'h00, exp});
  endtask

  task automatic op(input string tag, input logic ps, input logic pp,
                    input logic [10:0] exp_addr, input logic exp_sel);
    @(negedge clk);
    push_req = ps; pop_req = pp;
    #1;
    chk({tag, " addr"}, {5'd0, stk_addr}, {5'd0, exp_addr});
    chk({tag, " sel"}, {15'd0, stk_xram}, {15'd0, exp_sel});
    @(posedge clk); #1;
    push_req = 1'b0; pop_req = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 low byte", 8'h81, 8'h07);
    rd_chk("R1 extension", 8'hB7, 8'h00);
    rd_chk("R1 config", 8'hAF, 8'h00);
    #1;
    chk("R1 idle addr", {5'd0, stk_addr}, 16'h0007);
    chk("R1 idle sel", {15'd0, stk_xram}, 16'h0000);
  endtask

  task automatic t_push_pop;
    op("R2 push", 1'b1, 1'b0, 11'h008, 1'b0);
    rd_chk("R2 ptr after push", 8'h81, 8'h08);
    op("R3 pop", 1'b0, 1'b1, 11'h008, 1'b0);
    rd_chk("R3 ptr after pop", 8'h81, 8'h07);
  endtask

  task automatic t_normal_wrap;
    sfr_wr(8'h81, 8'hFF);
    op("R4 push wrap", 1'b1, 1'b0, 11'h000, 1'b0);
    rd_chk("R4 ptr wrapped", 8'h81, 8'h00);
    op("R4 pop wrap", 1'b0, 1'b1, 11'h000, 1'b0);
    rd_chk("R4 ptr back", 8'h81, 8'hFF);
  endtask

  task automatic t_cfg_and_hidden;
    sfr_wr(8'hB7, 8'h05);
    sfr_wr(8'hAF, 8'hFF);
    rd_chk("R7 config other bits zero", 8'hAF, 8'h80);
    rd_chk("R8 normal-mode write ignored", 8'hB7, 8'h00);
    rd_chk("R7 unmapped read", 8'h55, 8'h00);
  endtask

  task automatic t_ext_carry;
    sfr_wr(8'h81, 8'hFF);
    op("R5 push carry", 1'b1, 1'b0, 11'h100, 1'b1);
    rd_chk("R5 ext after carry", 8'hB7, 8'h01);
    rd_chk("R5 low after carry", 8'h81, 8'h00);
    op("R6 pop from 100h", 1'b0, 1'b1, 11'h100, 1'b1);
    rd_chk("R5 ext after borrow", 8'hB7, 8'h00);
    rd_chk("R5 low after borrow", 8'h81, 8'hFF);
    op("R6 idle at 0FFh", 1'b0, 1'b0, 11'h0FF, 1'b0);
  endtask

  task automatic t_unused_bits;
    sfr_wr(8'hB7, 8'hFE);
    rd_chk("R9 upper bits dropped", 8'hB7, 8'h06);
    op("R6 high idle", 1'b0, 1'b0, 11'h6FF, 1'b1);
    sfr_wr(8'hAF, 8'h00);
    op("R4 hidden ext in address", 1'b0, 1'b0, 11'h0FF, 1'b0);
    rd_chk("R8 hidden read", 8'hB7, 8'h00);
    sfr_wr(8'hAF, 8'h80);
    rd_chk("R8 value retained", 8'hB7, 8'h06);
  endtask

  task automatic t_priority;
    sfr_wr(8'hB7, 8'h00);
    sfr_wr(8'h81, 8'h10);
    @(negedge clk);
    push_req = 1'b1; sfr_wr_en = 1'b1; sfr_wr_addr = 8'h81; sfr_wr_data = 8'h40;
    #1;
    chk("R10 addr during write", {5'd0, stk_addr}, 16'h0010);
    @(posedge clk); #1;
    push_req = 1'b0; sfr_wr_en = 1'b0;
    rd_chk("R10 low from write", 8'h81, 8'h40);
    rd_chk("R10 ext untouched", 8'hB7, 8'h00);
    @(negedge clk);
    pop_req = 1'b1; sfr_wr_en = 1'b1; sfr_wr_addr = 8'hB7; sfr_wr_data = 8'h03;
    @(posedge clk); #1;
    pop_req = 1'b0; sfr_wr_en = 1'b0;
    rd_chk("R10 ext from write", 8'hB7, 8'h03);
    rd_chk("R10 low kept", 8'h81, 8'h40);
  endtask

  task automatic t_both;
    op("R11 push+pop", 1'b1, 1'b1, 11'h340, 1'b1);
    rd_chk("R11 low unchanged", 8'h81, 8'h40);
    rd_chk("R11 ext unchanged", 8'hB7, 8'h03);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; push_req = 1'b0; pop_req = 1'b0;
    sfr_wr_en = 1'b0; sfr_wr_addr = 8'h00; sfr_wr_data = 8'h00; sfr_rd_addr = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_push_pop();
    t_normal_wrap();
    t_cfg_and_hidden();
    t_ext_carry();
    t_unused_bits();
    t_priority();
    t_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule